// File: doc/BRIEF.md
# Indirect CSR Access Synchronizer

This block is a bridge on the host side of a chip. It gives a host access to a bank of up to 256 32-bit control/status registers that run on a separate, unrelated clock. The host sees only two words: a command word and a data word. For a write, the host loads the data word, then writes the command word with a target address, the direction bit cleared and the busy bit set. For a read, it writes the command word with the direction bit set and the busy bit set. The host then polls the busy bit. When busy reads 0 the access is complete, and for a read the data word holds the value returned by the target.

Inside, a launch flips a request toggle. A two-flop synchronizer carries the toggle into the target clock domain. There the bridge issues one single-cycle access on the target port, captures any read data on the next cycle, and flips an acknowledge toggle. A second two-flop synchronizer carries the acknowledge back to the host domain. Busy clears only when that synchronized acknowledge arrives. While busy is set, the captured address, direction and write data are frozen, so they are safe to sample from the other clock domain.

Top module: `idx_csr_bridge`

## Requirements
- R1: A host write to the command word (offset 0) while idle with bit 31 set launches one access, and bit 31 of the command word reads 1 from the next host cycle.
- R2: Busy (command bit 31) stays 1 until the access completes and then clears by itself. A host write of 0 to bit 31 does not clear it.
- R3: Command bit 30 selects the direction: 1 is a read (t_we low during the strobe), 0 is a write (t_we high during the strobe).
- R4: Command bits 7:0 hold the target address driven on t_addr. Command bits 29:8 always read 0, and values written to them are discarded.
- R5: For a write access, the data word (offset 4) is sent on t_wdata. For a read access, the data word is loaded with the target's read data before busy clears.
- R6: After reset the command and data words both read 0, and t_stb is low.
- R7: The command word is at host offset 0 and the data word is at offset 4. Writes to any other offset change nothing, and reads of other offsets return 0.
- R8: While busy is 1, host writes to the command word and to the data word are ignored.
- R9: Each launched access produces exactly one target clock cycle with t_stb high, and a write to the command word with bit 31 clear produces none.
- R10: The request and the acknowledge each cross their clock domain as a toggle through two flops, and busy clears only once the synchronized acknowledge matches the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| h_clk | input | 1 | Host clock |
| h_rst_n | input | 1 | Host-domain reset, active low |
| h_wr | input | 1 | Host write strobe, one cycle per write |
| h_off | input | 3 | Host byte offset: 0 is the command word, 4 is the data word |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for the word selected by h_off (combinational) |
| t_clk | input | 1 | Target clock |
| t_rst_n | input | 1 | Target-domain reset, active low |
| t_stb | output | 1 | Target access strobe, high for one target cycle |
| t_we | output | 1 | Target write enable, valid while t_stb is high |
| t_addr | output | 8 | Target register address |
| t_wdata | output | 32 | Target write data |
| t_rdata | input | 32 | Target read data, valid in the cycle after the strobe |

## Verification
The bench writes a distinct pattern to every one of the 256 target addresses and reads each one back, with the two clocks at unrelated periods. An address or data path that is off by one, or a read capture taken one cycle early, would return a neighbouring or stale value. It launches accesses and then writes new command and data values while busy is set. A bridge that lets these writes through would redirect the access, corrupt the write data, or drop busy early. It also counts target strobes per access, which exposes a pulse detector that fires twice or not at all. Finally, it writes to the reserved command bits and to an unused offset, and expects both to read back as zero with no effect.

// File: rtl/idx_pkg.sv
package idx_pkg;
  localparam int OFF_W    = 3;
  localparam int BUSY_BIT = 31;
  localparam int DIR_BIT  = 30;

  typedef enum logic [1:0] {SEL_NONE, SEL_CMD, SEL_DATA} sel_e;

  // Byte offset to word select: command at 0, data 4 bytes above.
  function automatic sel_e decode_off(input logic [OFF_W-1:0] off);
    case (off)
      3'd0:    return SEL_CMD;
      3'd4:    return SEL_DATA;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/idx_sync2.sv
module idx_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/idx_host_regs.sv
module idx_host_regs #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [idx_pkg::OFF_W-1:0] off,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  input  logic                    ack_s,
  input  logic [DW-1:0]           rd_hold,
  output logic                    req_tog,
  output logic [AW-1:0]           cmd_addr,
  output logic                    cmd_rd,
  output logic [DW-1:0]           data_q
);
  import idx_pkg::*;

  logic busy;
  sel_e sel;
  logic wr_ok, launch, done;

  assign sel    = decode_off(off);
  assign wr_ok  = wr && !busy;
  assign launch = wr_ok && (sel == SEL_CMD) && wdata[BUSY_BIT];
  assign done   = busy && (ack_s == req_tog);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cmd_rd   <= 1'b0;
      cmd_addr <= '0;
      data_q   <= '0;
      req_tog  <= 1'b0;
    end else begin
      if (wr_ok && sel == SEL_CMD) begin
        busy     <= wdata[BUSY_BIT];
        cmd_rd   <= wdata[DIR_BIT];
        cmd_addr <= wdata[AW-1:0];
      end
      if (launch) req_tog <= ~req_tog;
      if (done) busy <= 1'b0;
      if (wr_ok && sel == SEL_DATA) data_q <= wdata;
      else if (done && cmd_rd)      data_q <= rd_hold;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_CMD: begin
        rdata[BUSY_BIT] = busy;
        rdata[DIR_BIT]  = cmd_rd;
        rdata[AW-1:0]   = cmd_addr;
      end
      SEL_DATA: rdata = data_q;
      default:  rdata = '0;
    endcase
  end

  p_launch_sets_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy && (req_tog != $past(req_tog)));
  p_no_early_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (ack_s != req_tog)) |=> busy);
  p_frozen_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_addr) && $stable(cmd_rd));
  p_clear_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ack_s == req_tog));
  p_read_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmd_rd) |=> (data_q == $past(rd_hold)));
endmodule

// File: rtl/idx_tgt_port.sv
module idx_tgt_port #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_s,
  input  logic [AW-1:0] cmd_addr,
  input  logic          cmd_rd,
  input  logic [DW-1:0] data_q,
  output logic          t_stb,
  output logic          t_we,
  output logic [AW-1:0] t_addr,
  output logic [DW-1:0] t_wdata,
  input  logic [DW-1:0] t_rdata,
  output logic          ack_tog,
  output logic [DW-1:0] rd_hold
);
  logic req_prev, req_edge, stb_d;

  assign req_edge = req_s != req_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev <= 1'b0;
      t_stb    <= 1'b0;
      t_we     <= 1'b0;
      t_addr   <= '0;
      t_wdata  <= '0;
      stb_d    <= 1'b0;
      ack_tog  <= 1'b0;
      rd_hold  <= '0;
    end else begin
      req_prev <= req_s;
      t_stb    <= req_edge;
      stb_d    <= t_stb;
      if (req_edge) begin
        t_addr  <= cmd_addr;
        t_we    <= !cmd_rd;
        t_wdata <= data_q;
      end
      if (stb_d) begin
        ack_tog <= ~ack_tog;
        if (!t_we) rd_hold <= t_rdata;
      end
    end
  end

  p_stb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    t_stb |=> !t_stb);
  p_ack_after_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_tog != $past(ack_tog)) |-> $past(stb_d));
endmodule

// File: rtl/idx_csr_bridge.sv
module idx_csr_bridge #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          h_clk,
  input  logic          h_rst_n,
  input  logic          h_wr,
  input  logic [2:0]    h_off,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic          t_clk,
  input  logic          t_rst_n,
  output logic          t_stb,
  output logic          t_we,
  output logic [AW-1:0] t_addr,
  output logic [DW-1:0] t_wdata,
  input  logic [DW-1:0] t_rdata
);
  logic          req_tog, req_s, ack_tog, ack_s;
  logic [AW-1:0] cmd_addr;
  logic          cmd_rd;
  logic [DW-1:0] data_q, rd_hold;

  idx_host_regs #(.AW(AW), .DW(DW)) u_host (
    .clk(h_clk), .rst_n(h_rst_n), .wr(h_wr), .off(h_off), .wdata(h_wdata),
    .rdata(h_rdata), .ack_s(ack_s), .rd_hold(rd_hold), .req_tog(req_tog),
    .cmd_addr(cmd_addr), .cmd_rd(cmd_rd), .data_q(data_q)
  );

  idx_sync2 u_req_sync (.clk(t_clk), .rst_n(t_rst_n), .d(req_tog), .q(req_s));
  idx_sync2 u_ack_sync (.clk(h_clk), .rst_n(h_rst_n), .d(ack_tog), .q(ack_s));

  idx_tgt_port #(.AW(AW), .DW(DW)) u_tgt (
    .clk(t_clk), .rst_n(t_rst_n), .req_s(req_s), .cmd_addr(cmd_addr),
    .cmd_rd(cmd_rd), .data_q(data_q), .t_stb(t_stb), .t_we(t_we),
    .t_addr(t_addr), .t_wdata(t_wdata), .t_rdata(t_rdata),
    .ack_tog(ack_tog), .rd_hold(rd_hold)
  );
endmodule

// File: tb/idx_csr_bridge_bench.sv
module idx_csr_bridge_bench;
  logic        h_clk = 0, t_clk = 0, h_rst_n = 0, t_rst_n = 0;
  logic        h_wr = 0;
  logic [2:0]  h_off = 0;
  logic [31:0] h_wdata = 0, h_rdata;
  logic        t_stb, t_we;
  logic [7:0]  t_addr;
  logic [31:0] t_wdata, t_rdata;

  int checks = 0, errors = 0;
  int stb_cnt = 0;
  logic last_we = 0;
  logic [31:0] mem [256];

  always #10 h_clk = ~h_clk;
  always #17 t_clk = ~t_clk;

  idx_csr_bridge u_idx_csr_bridge (.*);

  always_ff @(posedge t_clk) begin
    if (t_stb) begin
      if (t_we) mem[t_addr] <= t_wdata;
      t_rdata <= mem[t_addr];
    end
  end

  always @(negedge t_clk) if (t_stb) begin stb_cnt++; last_we = t_we; end

  function automatic logic [31:0] pat(input logic [7:0] a);
    return {a, ~a, a ^ 8'h5A, a + 8'd3};
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] off, input logic [31:0] d);
    @(negedge h_clk); h_wr = 1; h_off = off; h_wdata = d;
    @(negedge h_clk); h_wr = 0;
  endtask

  task automatic hread(input logic [2:0] off, output logic [31:0] d);
    h_off = off; #1; d = h_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      @(negedge h_clk); hread(0, v);
      if (!v[31]) return;
    end
    check("R2 busy timeout", 32'h1, 32'h0);
  endtask

  task automatic access(input logic rd, input logic [7:0] a, input logic [31:0] d);
    if (!rd) hwrite(4, d);
    hwrite(0, {1'b1, rd, 22'b0, a});
    wait_idle();
  endtask

  initial begin
    repeat (190000) @(posedge h_clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s0, bad_stb, bad_we, bad_rd;
    t_rdata = 0;
    repeat (3) @(negedge h_clk);
    h_rst_n = 1; t_rst_n = 1;
    @(negedge h_clk);
    hread(0, v); check("R6 cmd reset", v, 32'h0);
    hread(4, v); check("R6 data reset", v, 32'h0);
    check("R6 t_stb reset", {31'b0, t_stb}, 32'h0);

    // R1: busy visible next host cycle
    hwrite(4, pat(8'h00));
    hwrite(0, 32'h8000_0000);
    hread(0, v); check("R1 busy after launch", {31'b0, v[31]}, 32'h1);
    wait_idle();

    // R5/R9/R3 full sweep: writes to every address, then reads
    bad_stb = 0; bad_we = 0; bad_rd = 0;
    for (int a = 0; a < 256; a++) begin
      s0 = stb_cnt;
      access(0, a[7:0], pat(a[7:0]));
      if (stb_cnt - s0 != 1) bad_stb++;
      if (last_we !== 1'b1) bad_we++;
    end
    check("R9 one strobe per write", bad_stb, 0);
    check("R3 write sets t_we", bad_we, 0);
    bad_stb = 0; bad_we = 0;
    for (int a = 0; a < 256; a++) begin
      s0 = stb_cnt;
      access(1, a[7:0], 0);
      if (stb_cnt - s0 != 1) bad_stb++;
      if (last_we !== 1'b0) bad_we++;
      hread(4, v);
      if (v !== pat(a[7:0])) bad_rd++;
      if (a % 64 == 0) check("R5 read data", v, pat(a[7:0]));
    end
    check("R4 R5 sweep mismatches", bad_rd, 0);
    check("R9 one strobe per read", bad_stb, 0);
    check("R3 read clears t_we", bad_we, 0);

    // R8/R2: writes while a read is in flight
    hwrite(0, 32'hC000_0010);
    hwrite(4, 32'hDEAD_0000);
    hwrite(0, 32'h0000_0077);
    hread(0, v); check("R2 R8 busy held, cmd frozen", v, 32'hC000_0010);
    wait_idle();
    hread(4, v); check("R8 R5 read result kept", v, pat(8'h10));
    hread(0, v); check("R2 self clear", v, 32'h4000_0010);

    // R8: data write during a write access
    hwrite(4, 32'h1234_5678);
    hwrite(0, 32'h8000_0020);
    hwrite(4, 32'hFFFF_0000);
    wait_idle();
    access(1, 8'h20, 0);
    hread(4, v); check("R8 write data frozen", v, 32'h1234_5678);

    // R4/R9: reserved bits, no launch without bit 31
    s0 = stb_cnt;
    hwrite(0, 32'h3FFF_FF55);
    hread(0, v); check("R4 reserved bits read 0", v, 32'h0000_0055);
    repeat (20) @(negedge h_clk);
    check("R9 no strobe without busy", stb_cnt - s0, 0);

    // R7: unused offset
    hwrite(2, 32'hAAAA_AAAA);
    hread(2, v); check("R7 unused offset reads 0", v, 32'h0);
    hread(4, v); check("R7 data untouched", v, 32'h1234_5678);
    hread(0, v); check("R7 cmd untouched", v, 32'h0000_0055);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule